// File: doc/BRIEF.md
# Rule-Constrained Trigger Generator

This block produces trigger accepts for a test stand that emulates a collider's bunch-crossing timeline. A crossing counter runs through an orbit of 3563 crossings. Candidates come from three sources: a periodic schedule within the orbit, a pseudo-random draw compared against a threshold, and falling edges on an external request line. The periodic schedule is set by a start delay, a spacing, a count per orbit, the number of orbits that carry triggers, and a repeat period in orbits.

Each candidate must pass four gates before it becomes a trigger. The run must be enabled. The candidate must not fall in the gap at the end of the orbit, unless blanking is switched off. The throttle state must be Ready whenever backpressure is honoured. Finally, four sliding-window rules must allow it. A candidate that fails a rule is dropped and counted as a violation. An accepted trigger appears as a one-cycle pulse and advances a trigger counter.

Top module: `trig_gen_top`

## Requirements
- R1: While reset is held, and after it is released, `trig_o` is 0, `trig_cnt` and `viol_cnt` are 0, and `bx_o` starts at 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: Once reset is released, `bx_o` advances by one every cycle and wraps from ORBIT_LEN-1 (3562) to 0. A trigger decided in the cycle where `bx_o` equals b is seen on `trig_o` in the next cycle.
- R3: Periodic schedule. The first periodic candidate of an orbit falls at crossing `first_dly`. Each further candidate falls `spacing` crossings after the previous one. With `burst_en`=1 at most `per_orbit` candidates occur per orbit; with `burst_en`=0 at most one occurs. `per_orbit`=0 gives none. The slot count restarts at every orbit wrap.
- R4: Orbit group. Orbits are counted from 0 while `run_en` is high, and periodic candidates occur only while that count is below `orbits_on`. With `rep_en`=1 the count returns to 0 at the wrap where count+1 >= `repeat_per`. With `rep_en`=0 it saturates at 255.
- R5: Random source. A 16-bit right-shifting Galois LFSR has feedback mask 0xB400 and reset value 0xACE1. On each step it shifts right and XORs in the mask when the bit shifted out was 1. It steps every cycle, and when `rand_en`=1 a candidate occurs whenever its current value is below `rand_thresh`.
- R6: An external candidate occurs in a cycle where `ext_trig_n` is 0 after being 1 in the previous cycle. A single falling edge gives exactly one trigger.
- R7: Rule k (k=1..4) takes its window N_k from `rule_win` bits [12k-1:12k-12]. The rule rejects a candidate when the k-th most recent accepted trigger happened fewer than N_k cycles ago. N_k=0 disables rule k. A rejected candidate that passed every other gate is dropped and increments `viol_cnt`.
- R8: With `bp_en`=1 and `throttle` not equal to 4'h8 (Ready), candidates are dropped without counting a violation.
- R9: Candidates at crossings `bx_o` >= ORBIT_LEN-GAP_LEN (3444) are dropped when `blank_dis`=0 and pass when `blank_dis`=1.
- R10: With `run_en`=0 no trigger is produced and the orbit-group count is held at 0.
- R11: `trig_cnt` increments by one for every accepted trigger and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Trigger run enable |
| burst_en | input | 1 | Allow more than one periodic trigger per orbit |
| rep_en | input | 1 | Repeat the orbit group |
| rand_en | input | 1 | Enable random candidates |
| bp_en | input | 1 | Honour throttle backpressure |
| blank_dis | input | 1 | Disable orbit-gap blanking |
| first_dly | input | 12 | Crossing of first periodic candidate |
| spacing | input | 12 | Crossings between periodic candidates |
| per_orbit | input | 8 | Periodic candidates per orbit |
| orbits_on | input | 8 | Orbits per group carrying periodic candidates |
| repeat_per | input | 8 | Group repeat period in orbits |
| rand_thresh | input | 16 | Random draw threshold |
| rule_win | input | 48 | Four 12-bit rule windows |
| throttle | input | 4 | Current throttle state |
| ext_trig_n | input | 1 | External trigger request, active on falling edge |
| bx_o | output | 12 | Current crossing number |
| trig_o | output | 1 | One-cycle trigger pulse |
| trig_cnt | output | 32 | Accepted trigger count |
| viol_cnt | output | 16 | Rule violation count |

## Verification
Several properties are checked on every cycle. No trigger may follow a crossing in the gap while blanking is on, or a cycle in which the run was off or the throttle held the block back. The crossing number must stay inside the orbit. The counter must move in step with the pulse. Two back-to-back triggers must never slip past a rule-1 window of two or more. The bench's scenarios are needed for the rest: the exact placement of periodic slots, the orbit-group and repeat sequence, the LFSR-driven random pattern, one trigger per external edge, and the deeper rules, where a trigger depends on history several triggers back. These run against a cycle model in the bench, together with directed counts over whole orbits.

// File: rtl/trig_gen_pkg.sv
package trig_gen_pkg;
  localparam logic [3:0]  THR_READY = 4'h8;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/trig_orbit_sched.sv
module trig_orbit_sched #(
  parameter int ORBIT_LEN = 3563,
  parameter int GAP_LEN   = 119,
  parameter int BX_W      = 12,
  parameter int ORB_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             burst_en,
  input  logic             rep_en,
  input  logic [BX_W-1:0]  first_dly,
  input  logic [BX_W-1:0]  spacing,
  input  logic [ORB_W-1:0] per_orbit,
  input  logic [ORB_W-1:0] orbits_on,
  input  logic [ORB_W-1:0] repeat_per,
  output logic [BX_W-1:0]  bx,
  output logic             per_cand,
  output logic             in_gap
);
  localparam logic [BX_W-1:0]  LAST_BX = BX_W'(ORBIT_LEN - 1);
  localparam logic [BX_W-1:0]  GAP_BX  = BX_W'(ORBIT_LEN - GAP_LEN);
  localparam logic [ORB_W-1:0] ORB_MAX = '1;

  logic [BX_W-1:0]  bx_q, bx_d;
  logic [BX_W:0]    nxt_q, nxt_d, target;
  logic [ORB_W-1:0] nf_q, nf_d, grp_q, grp_d, limit;
  logic             orb_end, grp_live, slot_hit, slot_en, grp_en;

  // next-state logic
  always_comb begin
    orb_end  = (bx_q == LAST_BX);
    bx_d     = orb_end ? '0 : bx_q + 1'b1;
    limit    = burst_en ? per_orbit : {{(ORB_W-1){1'b0}}, (per_orbit != '0)};
    grp_live = run_en && (grp_q < orbits_on);
    target   = (nf_q == '0) ? {1'b0, first_dly} : nxt_q;
    slot_hit = grp_live && (nf_q < limit) && ({1'b0, bx_q} == target);

    slot_en = orb_end || slot_hit;
    nf_d    = nf_q;
    nxt_d   = nxt_q;
    if (orb_end) begin
      nf_d = '0;
    end else if (slot_hit) begin
      nf_d  = nf_q + 1'b1;
      nxt_d = {1'b0, bx_q} + {1'b0, spacing};
    end

    grp_en = !run_en || orb_end;
    grp_d  = grp_q;
    if (!run_en) begin
      grp_d = '0;
    end else if (orb_end) begin
      if (rep_en && (({1'b0, grp_q} + 1'b1) >= {1'b0, repeat_per}))
        grp_d = '0;
      else if (grp_q != ORB_MAX)
        grp_d = grp_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q <= '0;
    end else begin
      bx_q <= bx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_q  <= '0;
      nxt_q <= '0;
    end else if (slot_en) begin
      nf_q  <= nf_d;
      nxt_q <= nxt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (grp_en) begin
      grp_q <= grp_d;
    end
  end

  assign bx       = bx_q;
  assign per_cand = slot_hit;
  assign in_gap   = (bx_q >= GAP_BX);
endmodule

// File: rtl/trig_lfsr.sv
module trig_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = trig_gen_pkg::LFSR_TAPS,
  parameter logic [W-1:0] SEED = trig_gen_pkg::LFSR_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q >> 1;
    if (st_q[0]) st_d = st_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else begin
      st_q <= st_d;
    end
  end

  assign value = st_q;
endmodule

// File: rtl/trig_rule_bank.sv
module trig_rule_bank #(
  parameter int NUM_RULES = 4,
  parameter int WIN_W     = 12,
  localparam int AGE_W    = WIN_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic [NUM_RULES*WIN_W-1:0] rule_win,
  output logic                       rule_ok
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q [NUM_RULES];
  logic [AGE_W-1:0] age_d [NUM_RULES];
  logic [AGE_W-1:0] age_inc [NUM_RULES];
  logic [NUM_RULES-1:0] pass;

  for (genvar k = 0; k < NUM_RULES; k++) begin : g_rule
    logic [WIN_W-1:0] win;
    assign win        = rule_win[k*WIN_W +: WIN_W];
    assign age_inc[k] = (age_q[k] == AGE_MAX) ? AGE_MAX : age_q[k] + 1'b1;
    // rule k+1: the (k+1)-th most recent trigger must be at least win cycles old
    assign pass[k]    = (win == '0) || (age_q[k] >= {1'b0, win});

    if (k == 0) begin : g_head
      assign age_d[k] = accept ? AGE_W'(1) : age_inc[k];
    end else begin : g_tail
      assign age_d[k] = accept ? age_inc[k-1] : age_inc[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[k] <= AGE_MAX;
      end else begin
        age_q[k] <= age_d[k];
      end
    end
  end

  assign rule_ok = &pass;
endmodule

// File: rtl/trig_gen_top.sv
module trig_gen_top
  import trig_gen_pkg::*;
#(
  parameter int ORBIT_LEN = 3563,
  parameter int GAP_LEN   = 119,
  parameter int BX_W      = 12,
  parameter int ORB_W     = 8,
  parameter int WIN_W     = 12,
  parameter int NUM_RULES = 4,
  parameter int RND_W     = 16,
  parameter int TCNT_W    = 32,
  parameter int VCNT_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_en,
  input  logic                       burst_en,
  input  logic                       rep_en,
  input  logic                       rand_en,
  input  logic                       bp_en,
  input  logic                       blank_dis,
  input  logic [BX_W-1:0]            first_dly,
  input  logic [BX_W-1:0]            spacing,
  input  logic [ORB_W-1:0]           per_orbit,
  input  logic [ORB_W-1:0]           orbits_on,
  input  logic [ORB_W-1:0]           repeat_per,
  input  logic [RND_W-1:0]           rand_thresh,
  input  logic [NUM_RULES*WIN_W-1:0] rule_win,
  input  logic [3:0]                 throttle,
  input  logic                       ext_trig_n,
  output logic [BX_W-1:0]            bx_o,
  output logic                       trig_o,
  output logic [TCNT_W-1:0]          trig_cnt,
  output logic [VCNT_W-1:0]          viol_cnt
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              per_cand, in_gap, rule_ok;
  logic [RND_W-1:0]  rnd;
  logic              ext_prev_q;
  logic              cand, blanked, held, elig, accept, viol;
  logic              trig_q;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [VCNT_W-1:0] vcnt_q, vcnt_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_i_n = rs_q[1];

  trig_orbit_sched #(
    .ORBIT_LEN(ORBIT_LEN), .GAP_LEN(GAP_LEN), .BX_W(BX_W), .ORB_W(ORB_W)
  ) u_sched (
    .clk(clk), .rst_n(rst_i_n), .run_en(run_en), .burst_en(burst_en),
    .rep_en(rep_en), .first_dly(first_dly), .spacing(spacing),
    .per_orbit(per_orbit), .orbits_on(orbits_on), .repeat_per(repeat_per),
    .bx(bx_o), .per_cand(per_cand), .in_gap(in_gap)
  );

  trig_lfsr #(.W(RND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_i_n), .value(rnd)
  );

  trig_rule_bank #(.NUM_RULES(NUM_RULES), .WIN_W(WIN_W)) u_rules (
    .clk(clk), .rst_n(rst_i_n), .accept(accept), .rule_win(rule_win),
    .rule_ok(rule_ok)
  );

  // candidate merge and gating
  always_comb begin
    cand    = per_cand || (rand_en && (rnd < rand_thresh)) ||
              (ext_prev_q && !ext_trig_n);
    blanked = in_gap && !blank_dis;
    held    = bp_en && (throttle != THR_READY);
    elig    = cand && run_en && !blanked && !held;
    accept  = elig && rule_ok;
    viol    = elig && !rule_ok;
    tcnt_d  = tcnt_q + 1'b1;
    vcnt_d  = vcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ext_prev_q <= 1'b1;
      trig_q     <= 1'b0;
    end else begin
      ext_prev_q <= ext_trig_n;
      trig_q     <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tcnt_q <= '0;
    end else if (accept) begin
      tcnt_q <= tcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vcnt_q <= '0;
    end else if (viol) begin
      vcnt_q <= vcnt_d;
    end
  end

  assign trig_o   = trig_q;
  assign trig_cnt = tcnt_q;
  assign viol_cnt = vcnt_q;
endmodule

// File: rtl/trig_gen_chk.sv
module trig_gen_chk #(
  parameter int ORBIT_LEN = 3563,
  parameter int GAP_LEN   = 119,
  parameter int BX_W      = 12,
  parameter int WIN_W     = 12,
  parameter int TCNT_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              bp_en,
  input logic              blank_dis,
  input logic [3:0]        throttle,
  input logic [WIN_W-1:0]  win1,
  input logic [BX_W-1:0]   bx_o,
  input logic              trig_o,
  input logic [TCNT_W-1:0] trig_cnt
);
  // R2
  bx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bx_o < BX_W'(ORBIT_LEN));

  // R9
  gap_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !$past(blank_dis)) |-> ($past(bx_o) < BX_W'(ORBIT_LEN - GAP_LEN)));

  // R8
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bp_en && (throttle != trig_gen_pkg::THR_READY)) |-> !trig_o);

  // R10
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> !trig_o);

  // R7
  rule1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $past(trig_o)) |-> ($past(win1) <= WIN_W'(1)));

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (trig_cnt == $past(trig_cnt) + 1'b1));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_o |-> $stable(trig_cnt));
endmodule

bind trig_gen_top trig_gen_chk #(
  .ORBIT_LEN(ORBIT_LEN), .GAP_LEN(GAP_LEN), .BX_W(BX_W), .WIN_W(WIN_W),
  .TCNT_W(TCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_i_n), .run_en(run_en), .bp_en(bp_en),
  .blank_dis(blank_dis), .throttle(throttle), .win1(rule_win[WIN_W-1:0]),
  .bx_o(bx_o), .trig_o(trig_o), .trig_cnt(trig_cnt)
);

// File: tb/tb_trig_gen_top.sv
module tb_trig_gen_top;
  localparam int ORBIT = 3563;
  localparam int GAP   = 119;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, run_en, burst_en, rep_en, rand_en, bp_en, blank_dis;
  logic [11:0] first_dly, spacing;
  logic [7:0]  per_orbit, orbits_on, repeat_per;
  logic [15:0] rand_thresh;
  logic [47:0] rule_win;
  logic [3:0]  throttle;
  logic        ext_trig_n;
  logic [11:0] bx_o;
  logic        trig_o;
  logic [31:0] trig_cnt;
  logic [15:0] viol_cnt;

  trig_gen_top dut (.*);

  int total = 0, bad = 0;
  string cur_req = "R1";
  int ext_pct = 0, thr_pct = 0;

  // reference state
  int m_bx, m_nf, m_nxt, m_grp, m_prev, m_rs, m_trig;
  int m_age[4];
  logic [15:0] m_lfsr;
  longint m_tcnt, m_vcnt;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_le(string req, string what, longint act, longint lim);
    total++;
    if (act > lim) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected<=%0d", req, what, act, lim);
    end
  endtask

  task automatic m_reset();
    m_bx = 0; m_nf = 0; m_nxt = 0; m_grp = 0; m_prev = 1; m_trig = 0;
    m_lfsr = 16'hACE1; m_tcnt = 0; m_vcnt = 0;
    for (int i = 0; i < 4; i++) m_age[i] = 8191;
  endtask

  function automatic int sat(int a);
    return (a >= 8191) ? 8191 : a + 1;
  endfunction

  task automatic model_step();
    bit orb_end, live, hit, cand, elig, ok, acc, vio;
    int lim, target, w;
    if (!rst_n) begin m_rs = 0; m_reset(); return; end
    if (m_rs < 2) begin m_reset(); m_rs = ((m_rs << 1) | 1) & 3; return; end
    orb_end = (m_bx == ORBIT - 1);
    lim     = burst_en ? int'(per_orbit) : (per_orbit != 0 ? 1 : 0);
    live    = run_en && (m_grp < int'(orbits_on));
    target  = (m_nf == 0) ? int'(first_dly) : m_nxt;
    hit     = live && (m_nf < lim) && (m_bx == target);
    cand    = hit || (rand_en && (m_lfsr < rand_thresh)) || (m_prev == 1 && !ext_trig_n);
    elig    = cand && run_en && !((m_bx >= ORBIT - GAP) && !blank_dis) &&
              !(bp_en && throttle != 4'h8);
    ok = 1;
    for (int k = 0; k < 4; k++) begin
      w = int'(rule_win[12*k +: 12]);
      if (w != 0 && m_age[k] < w) ok = 0;
    end
    acc = elig && ok;
    vio = elig && !ok;
    if (acc) begin
      for (int i = 3; i > 0; i--) m_age[i] = sat(m_age[i-1]);
      m_age[0] = 1;
    end else begin
      for (int i = 0; i < 4; i++) m_age[i] = sat(m_age[i]);
    end
    m_trig = acc;
    m_tcnt = (m_tcnt + acc) & 64'hFFFF_FFFF;
    m_vcnt = (m_vcnt + vio) & 64'hFFFF;
    if (!run_en) m_grp = 0;
    else if (orb_end) begin
      if (rep_en && (m_grp + 1 >= int'(repeat_per))) m_grp = 0;
      else if (m_grp < 255) m_grp++;
    end
    if (orb_end) m_nf = 0;
    else if (hit) begin m_nf++; m_nxt = m_bx + int'(spacing); end
    m_bx   = orb_end ? 0 : m_bx + 1;
    m_prev = ext_trig_n;
    m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 16'hB400) : (m_lfsr >> 1);
  endtask

  // one cycle: random per-cycle inputs, model, then compare at the next negedge
  task automatic tick();
    if (ext_pct > 0 && ($urandom % 100) < ext_pct) ext_trig_n = ~ext_trig_n;
    if (thr_pct > 0) throttle = (($urandom % 100) < thr_pct) ? 4'($urandom % 8) : 4'h8;
    model_step();
    @(negedge clk);
    if (rst_n) begin
      if (bx_o != 12'(m_bx)) chk("R2", "bx_o", bx_o, m_bx);
      if (trig_o != m_trig[0]) chk(cur_req, "trig_o", trig_o, m_trig);
      if (trig_cnt != m_tcnt) chk("R11", "trig_cnt", trig_cnt, m_tcnt);
      if (viol_cnt != m_vcnt) chk("R7", "viol_cnt", viol_cnt, m_vcnt);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic quiet();
    run_en = 0; burst_en = 0; rep_en = 0; rand_en = 0; bp_en = 0; blank_dis = 0;
    first_dly = 0; spacing = 0; per_orbit = 0; orbits_on = 0; repeat_per = 0;
    rand_thresh = 0; rule_win = '0; throttle = 4'h8; ext_pct = 0; thr_pct = 0;
  endtask

  longint c0, v0;
  int gap_hits;

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    ext_trig_n = 1'b1;
    rst_n = 1'b0;
    run(3);
    // R1 during reset
    chk("R1", "trig_o in reset", trig_o, 0);
    chk("R1", "trig_cnt in reset", trig_cnt, 0);
    chk("R1", "bx_o in reset", bx_o, 0);
    rst_n = 1'b1;
    run(3);
    chk("R1", "viol_cnt after reset", viol_cnt, 0);
    chk("R2", "bx_o after release", bx_o, 1);
    chk("R1", "trig_o after reset", trig_o, 0);

    // R3 periodic burst
    cur_req = "R3";
    first_dly = 12'd10; spacing = 12'd100; per_orbit = 8'd5; burst_en = 1;
    orbits_on = 8'd255; run_en = 1;
    run(ORBIT);
    c0 = trig_cnt; run(ORBIT);
    chk("R3", "burst triggers per orbit", trig_cnt - c0, 5);
    burst_en = 0;
    run(ORBIT);
    c0 = trig_cnt; run(ORBIT);
    chk("R3", "single trigger per orbit", trig_cnt - c0, 1);
    per_orbit = 8'd0;
    c0 = trig_cnt; run(ORBIT);
    chk("R3", "zero per orbit", trig_cnt - c0, 0);

    // R4 orbit group with repeats
    cur_req = "R4";
    run_en = 0; run(5);
    per_orbit = 8'd3; burst_en = 1; first_dly = 12'd200; spacing = 12'd7;
    orbits_on = 8'd2; rep_en = 1; repeat_per = 8'd3; run_en = 1;
    run(7 * ORBIT);
    rep_en = 0; run_en = 0; run(5);
    orbits_on = 8'd1; run_en = 1;
    run(ORBIT + 100);
    c0 = trig_cnt; run(2 * ORBIT);
    chk("R4", "no triggers after group without repeats", trig_cnt - c0, 0);

    // R10 run disabled
    cur_req = "R10";
    run_en = 0; rand_en = 1; rand_thresh = 16'hFFFF; ext_pct = 30;
    c0 = trig_cnt; run(1000);
    chk("R10", "run off triggers", trig_cnt - c0, 0);
    ext_pct = 0; ext_trig_n = 1;

    // R5 random
    cur_req = "R5";
    run_en = 1; per_orbit = 0; rand_thresh = 16'h0800;
    run(ORBIT);
    rand_thresh = 16'h0000;
    c0 = trig_cnt; run(1000);
    chk("R5", "threshold zero gives nothing", trig_cnt - c0, 0);
    rand_en = 0;

    // R6 external edges
    cur_req = "R6";
    while (bx_o > 12'd100) tick();
    c0 = trig_cnt;
    ext_trig_n = 0; run(6); ext_trig_n = 1; run(6);
    chk("R6", "one trigger per falling edge", trig_cnt - c0, 1);
    ext_pct = 20; run(ORBIT); ext_pct = 0; ext_trig_n = 1;

    // R7 rules
    cur_req = "R7";
    rand_en = 1; rand_thresh = 16'h8000;
    rule_win = {12'd60, 12'd30, 12'd10, 12'd3};
    run(ORBIT);
    while (bx_o > 12'd100) tick();
    rand_thresh = 16'hFFFF; rule_win = {36'd0, 12'd5};
    c0 = trig_cnt; v0 = viol_cnt; run(500);
    chk_le("R7", "rule1 window 5 over 500 cycles", trig_cnt - c0, 101);
    chk_le("R7", "violations recorded", 1, viol_cnt - v0);

    // R8 backpressure
    cur_req = "R8";
    rule_win = '0; bp_en = 1; throttle = 4'h2;
    while (bx_o > 12'd100) tick();
    c0 = trig_cnt; v0 = viol_cnt; run(500);
    chk("R8", "held triggers", trig_cnt - c0, 0);
    chk("R8", "held not counted as violations", viol_cnt - v0, 0);
    rand_thresh = 16'h4000; thr_pct = 40; rule_win = {12'd0, 12'd0, 12'd8, 12'd2};
    run(ORBIT);
    thr_pct = 0; throttle = 4'h8; bp_en = 0;

    // R9 gap blanking
    cur_req = "R9";
    rule_win = '0; rand_thresh = 16'hFFFF; gap_hits = 0;
    for (int i = 0; i < 2 * ORBIT; i++) begin
      int b;
      b = int'(bx_o);
      tick();
      if (trig_o && b >= ORBIT - GAP) gap_hits++;
    end
    chk("R9", "triggers inside gap while blanked", gap_hits, 0);
    blank_dis = 1; gap_hits = 0;
    for (int i = 0; i < ORBIT; i++) begin
      int b;
      b = int'(bx_o);
      tick();
      if (trig_o && b >= ORBIT - GAP) gap_hits++;
    end
    chk_le("R9", "gap triggers with blanking off", 1, gap_hits);

    // mixed random configurations
    cur_req = "R11";
    for (int r = 0; r < 4; r++) begin
      run_en = 1; burst_en = 1'($urandom); rep_en = 1'($urandom);
      rand_en = 1'($urandom); bp_en = 1'($urandom); blank_dis = 1'($urandom);
      first_dly = 12'($urandom % ORBIT); spacing = 12'($urandom % 300);
      per_orbit = 8'($urandom % 20); orbits_on = 8'($urandom % 4);
      repeat_per = 8'($urandom % 4); rand_thresh = 16'($urandom % 16'h2000);
      rule_win = {12'($urandom % 200), 12'($urandom % 100),
                  12'($urandom % 50), 12'($urandom % 10)};
      ext_pct = 5; thr_pct = 20;
      run(ORBIT);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule